// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block is the per-processor end of a vectored interrupt scheme. It keeps three 256-entry bit vectors: pending requests, vectors in service, and the trigger mode of each vector. A higher vector number has higher priority. The controller raises a request line towards the processor when the best pending vector beats both the best vector in service and the current task-priority class. Everything sits behind strobes. A trigger strobe carries a vector, its trigger mode and an external-interrupt flag. An acknowledge strobe moves the best pending vector into service and returns its number, or returns the spurious vector if the request has gone stale. An end-of-interrupt strobe retires the best vector in service and, for level-triggered vectors, tells the interrupt sources through a broadcast strobe.

The task priority and the spurious-vector register are written through their own strobes. The processor priority and the arbitration priority are available at all times as outputs. An illegal-vector error bit records any trigger whose vector falls below the first usable vector.

Top module: `ipc_top`

## Requirements
- R1: An accepted trigger marks the vector pending and records its trigger mode (trigLevel 1 = level, 0 = edge); a level vector later retired by end-of-interrupt produces a one-cycle eoiBcastValid with eoiBcastVector equal to that vector.
- R2: A trigger with a vector below FIRST_VEC (default 16) is discarded, and errIllegalVec goes to 1 on the next cycle and stays at 1 until reset.
- R3: A trigger for a vector that is already pending, with trigExtInt 0, is ignored, and the trigger mode stored earlier is kept.
- R4: A trigger with trigExtInt 1 skips the already-pending check, so it rewrites the stored trigger mode of a pending vector.
- R5: intr is raised only when the best pending vector is numerically above the best in-service vector (or nothing is in service) and its class (bits 7:4) is above the task-priority class (tprData bits 7:4).
- R6: procPriority equals the task priority when nothing is in service or the task-priority class is at least the class of the best in-service vector; otherwise it equals that vector with bits 3:0 cleared.
- R7: Each ackStrobe gives ackValid for one cycle on the next cycle. ackVector is the best pending vector, which moves from pending to in service, unless nothing is pending or that vector with bits 3:0 cleared is not above procPriority. In those cases ackVector is the spurious vector (spurReg bits 7:0) and nothing moves.
- R8: An eoiStrobe clears the best in-service vector unless it equals the spurious vector. When that vector was level-triggered it also clears the stored mode and emits the broadcast of R1.
- R9: A task-priority write with a lower value than the current one causes intr to be re-evaluated; a higher value never drops an intr that is already raised.
- R10: spurReg bits 3:0 always read 1; a spurious write loads bits 7:4 from spurData bits 7:4, bit 8 (software enable) and bit 9 (focus disable) from the same bits.
- R11: arbPriority equals the task priority when its class is at least the pending class and above the in-service class; otherwise it is the larger of (task class AND in-service class) and the pending class, shifted into bits 7:4 (an empty vector counts as class 0).
- R12: After reset nothing is pending or in service, intr is 0, the task priority and procPriority are 0, spurReg is 0x0FF and errIllegalVec is 0.
- R13: intr is re-evaluated on the cycle after an accepted trigger, a serviced acknowledge, a retiring end-of-interrupt or a lowering task-priority write; so it rises two clock edges after the trigger edge, and it is 0 in the cycle after any ackStrobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigValid | input | 1 | Trigger request strobe |
| trigVector | input | 8 | Vector of the trigger |
| trigLevel | input | 1 | Trigger mode, 1 = level, 0 = edge |
| trigExtInt | input | 1 | External-interrupt delivery, skips the pending check |
| ackStrobe | input | 1 | Processor acknowledge |
| eoiStrobe | input | 1 | End-of-interrupt write |
| tprWrite | input | 1 | Task-priority write strobe |
| tprData | input | 8 | New task priority |
| spurWrite | input | 1 | Spurious-vector register write strobe |
| spurData | input | 10 | New spurious register value |
| intr | output | 1 | Interrupt request to the processor |
| ackValid | output | 1 | ackVector is valid |
| ackVector | output | 8 | Acknowledged or spurious vector |
| eoiBcastValid | output | 1 | End-of-interrupt broadcast strobe |
| eoiBcastVector | output | 8 | Vector carried by the broadcast |
| procPriority | output | 8 | Processor priority |
| arbPriority | output | 8 | Arbitration priority |
| spurReg | output | 10 | Spurious register read value |
| errIllegalVec | output | 1 | Sticky illegal-vector error |

## Verification
A wrong bit in the pending or in-service vectors shows up at procPriority and arbPriority on the very next cycle, and at ackVector on the next acknowledge, so a lock-step reference model compares these outputs on every cycle. A lost trigger mode is silent until the vector is retired, so the directed cases pair each duplicate or external trigger with an acknowledge and an end-of-interrupt, and then look for the broadcast or its absence. Mistakes in intr timing or gating show within two cycles of the event that should have caused a re-evaluation. The random phase reuses a small set of vectors so that collisions, stale acknowledges and retirement of the spurious vector keep occurring.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int VEC_W   = 8;
  localparam int CLASS_W = 4;
  localparam int LOW_W   = VEC_W - CLASS_W;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int SPUR_W  = VEC_W + 2;

  typedef logic [VEC_W-1:0] vec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              trigSet;
    vec_t              trigVec;
    logic              trigLevel;
    logic              ackMove;
    logic              eoiClear;
    logic              tprLoad;
    vec_t              tprVal;
    logic              spurLoad;
    logic [SPUR_W-1:0] spurVal;
  } strobe_t;
endpackage

// File: rtl/ipc_prio_enc.sv
module ipc_prio_enc #(
  parameter int W  = 256,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  bits,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = i[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/ipc_datapath.sv
module ipc_datapath
  import ipc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  output logic              irrAny,
  output vec_t              topIrr,
  output logic              isrAny,
  output vec_t              topIsr,
  output logic              tmrTopIsr,
  output logic              irrAtTrig,
  output vec_t              tpr,
  output vec_t              ppr,
  output vec_t              apr,
  output logic [SPUR_W-1:0] spur
);
  logic [NUM_VEC-1:0] irr, isr, tmr;
  logic [NUM_VEC-1:0] trigMask, ackMask, eoiMask, tmrNext;
  logic [CLASS_W-1:0] tprC, isrC, irrC, andC;

  ipc_prio_enc #(.W(NUM_VEC), .IW(VEC_W)) uIrrEnc (.bits(irr), .found(irrAny), .idx(topIrr));
  ipc_prio_enc #(.W(NUM_VEC), .IW(VEC_W)) uIsrEnc (.bits(isr), .found(isrAny), .idx(topIsr));

  localparam logic [NUM_VEC-1:0] ONE = {{(NUM_VEC-1){1'b0}}, 1'b1};

  assign trigMask  = stb.trigSet  ? (ONE << stb.trigVec) : '0;
  assign ackMask   = stb.ackMove  ? (ONE << topIrr)      : '0;
  assign eoiMask   = stb.eoiClear ? (ONE << topIsr)      : '0;
  assign irrAtTrig = irr[stb.trigVec];
  assign tmrTopIsr = tmr[topIsr];

  always_comb begin
    tmrNext = tmr & ~eoiMask;
    if (stb.trigSet) tmrNext[stb.trigVec] = stb.trigLevel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irr  <= '0;
      isr  <= '0;
      tmr  <= '0;
      tpr  <= '0;
      spur <= {2'b00, {VEC_W{1'b1}}};
    end else begin
      irr <= (irr & ~ackMask) | trigMask;
      isr <= (isr & ~eoiMask) | ackMask;
      tmr <= tmrNext;
      if (stb.tprLoad)  tpr  <= stb.tprVal;
      if (stb.spurLoad) spur <= {stb.spurVal[SPUR_W-1:LOW_W], {LOW_W{1'b1}}};
    end
  end

  assign tprC = tpr[VEC_W-1 -: CLASS_W];
  assign isrC = isrAny ? topIsr[VEC_W-1 -: CLASS_W] : '0;
  assign irrC = irrAny ? topIrr[VEC_W-1 -: CLASS_W] : '0;
  assign andC = tprC & isrC;

  always_comb begin
    if (!isrAny || tprC >= isrC) ppr = tpr;
    else                         ppr = {isrC, {LOW_W{1'b0}}};
    if (tprC >= irrC && tprC > isrC) apr = tpr;
    else if (andC > irrC)            apr = {andC, {LOW_W{1'b0}}};
    else                             apr = {irrC, {LOW_W{1'b0}}};
  end
endmodule

// File: rtl/ipc_control.sv
module ipc_control
  import ipc_pkg::*;
#(
  parameter int FIRST_VEC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigValid,
  input  vec_t              trigVector,
  input  logic              trigLevel,
  input  logic              trigExtInt,
  input  logic              ackStrobe,
  input  logic              eoiStrobe,
  input  logic              tprWrite,
  input  vec_t              tprData,
  input  logic              spurWrite,
  input  logic [SPUR_W-1:0] spurData,
  input  logic              irrAny,
  input  vec_t              topIrr,
  input  logic              isrAny,
  input  vec_t              topIsr,
  input  logic              tmrTopIsr,
  input  logic              irrAtTrig,
  input  vec_t              tpr,
  input  vec_t              ppr,
  input  logic [SPUR_W-1:0] spur,
  output strobe_t           stb,
  output logic              intr,
  output logic              ackValid,
  output vec_t              ackVector,
  output logic              eoiBcastValid,
  output vec_t              eoiBcastVector,
  output logic              errIllegalVec
);
  logic trigLegal, trigAccept, ackServe, eoiDo, tprLower, eligible, evalPend;
  vec_t irrClassVec;

  assign trigLegal   = trigVector >= vec_t'(FIRST_VEC);
  assign trigAccept  = trigValid && trigLegal && (!irrAtTrig || trigExtInt);
  assign irrClassVec = {topIrr[VEC_W-1 -: CLASS_W], {LOW_W{1'b0}}};
  assign ackServe    = ackStrobe && irrAny && (irrClassVec > ppr);
  assign eoiDo       = eoiStrobe && isrAny && (topIsr != spur[VEC_W-1:0]);
  assign tprLower    = tprWrite && (tprData < tpr);
  assign eligible    = irrAny && (!isrAny || topIrr > topIsr) &&
                       (topIrr[VEC_W-1 -: CLASS_W] > tpr[VEC_W-1 -: CLASS_W]);

  always_comb begin
    stb.trigSet   = trigAccept;
    stb.trigVec   = trigVector;
    stb.trigLevel = trigLevel;
    stb.ackMove   = ackServe;
    stb.eoiClear  = eoiDo;
    stb.tprLoad   = tprWrite;
    stb.tprVal    = tprData;
    stb.spurLoad  = spurWrite;
    stb.spurVal   = spurData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intr           <= 1'b0;
      evalPend       <= 1'b0;
      ackValid       <= 1'b0;
      ackVector      <= '0;
      eoiBcastValid  <= 1'b0;
      eoiBcastVector <= '0;
      errIllegalVec  <= 1'b0;
    end else begin
      intr           <= ackStrobe ? 1'b0 : (intr || (evalPend && eligible));
      evalPend       <= trigAccept || ackServe || eoiDo || tprLower;
      ackValid       <= ackStrobe;
      if (ackStrobe) ackVector <= ackServe ? topIrr : spur[VEC_W-1:0];
      eoiBcastValid  <= eoiDo && tmrTopIsr;
      if (eoiDo) eoiBcastVector <= topIsr;
      errIllegalVec  <= errIllegalVec || (trigValid && !trigLegal);
    end
  end
endmodule

// File: rtl/ipc_top.sv
module ipc_top
  import ipc_pkg::*;
#(
  parameter int FIRST_VEC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigValid,
  input  logic [VEC_W-1:0]  trigVector,
  input  logic              trigLevel,
  input  logic              trigExtInt,
  input  logic              ackStrobe,
  input  logic              eoiStrobe,
  input  logic              tprWrite,
  input  logic [VEC_W-1:0]  tprData,
  input  logic              spurWrite,
  input  logic [SPUR_W-1:0] spurData,
  output logic              intr,
  output logic              ackValid,
  output logic [VEC_W-1:0]  ackVector,
  output logic              eoiBcastValid,
  output logic [VEC_W-1:0]  eoiBcastVector,
  output logic [VEC_W-1:0]  procPriority,
  output logic [VEC_W-1:0]  arbPriority,
  output logic [SPUR_W-1:0] spurReg,
  output logic              errIllegalVec
);
  strobe_t stb;
  logic irrAny, isrAny, tmrTopIsr, irrAtTrig;
  vec_t topIrr, topIsr, tpr;

  ipc_datapath uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .irrAny(irrAny), .topIrr(topIrr), .isrAny(isrAny), .topIsr(topIsr),
    .tmrTopIsr(tmrTopIsr), .irrAtTrig(irrAtTrig), .tpr(tpr),
    .ppr(procPriority), .apr(arbPriority), .spur(spurReg)
  );

  ipc_control #(.FIRST_VEC(FIRST_VEC)) uCtl (
    .clk(clk), .rstN(rstN),
    .trigValid(trigValid), .trigVector(trigVector), .trigLevel(trigLevel),
    .trigExtInt(trigExtInt), .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe),
    .tprWrite(tprWrite), .tprData(tprData), .spurWrite(spurWrite), .spurData(spurData),
    .irrAny(irrAny), .topIrr(topIrr), .isrAny(isrAny), .topIsr(topIsr),
    .tmrTopIsr(tmrTopIsr), .irrAtTrig(irrAtTrig), .tpr(tpr), .ppr(procPriority),
    .spur(spurReg), .stb(stb), .intr(intr), .ackValid(ackValid), .ackVector(ackVector),
    .eoiBcastValid(eoiBcastValid), .eoiBcastVector(eoiBcastVector),
    .errIllegalVec(errIllegalVec)
  );
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker
  import ipc_pkg::*;
#(
  parameter int FIRST_VEC = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              trigValid,
  input logic [VEC_W-1:0]  trigVector,
  input logic              ackStrobe,
  input logic              eoiStrobe,
  input logic              intr,
  input logic              ackValid,
  input logic              eoiBcastValid,
  input logic [SPUR_W-1:0] spurReg,
  input logic              errIllegalVec
);
  // R7
  ack_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe |=> ackValid);
  // R7
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ackStrobe |=> !ackValid);
  // R13
  intr_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe |=> !intr);
  // R8
  eoi_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    eoiBcastValid |-> $past(eoiStrobe));
  // R2
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errIllegalVec |=> errIllegalVec);
  // R2
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errIllegalVec) |-> $past(trigValid && (trigVector < vec_t'(FIRST_VEC))));
  // R10
  spur_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    spurReg[LOW_W-1:0] == {LOW_W{1'b1}});
endmodule

bind ipc_top ipc_checker #(.FIRST_VEC(FIRST_VEC)) uChk (
  .clk(clk), .rstN(rstN), .trigValid(trigValid), .trigVector(trigVector),
  .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe), .intr(intr), .ackValid(ackValid),
  .eoiBcastValid(eoiBcastValid), .spurReg(spurReg), .errIllegalVec(errIllegalVec)
);

// File: tb/sim_ipc_top.sv
module sim_ipc_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigValid = 0, trigLevel = 0, trigExtInt = 0, ackStrobe = 0, eoiStrobe = 0;
  logic tprWrite = 0, spurWrite = 0;
  logic [7:0] trigVector = 0, tprData = 0;
  logic [9:0] spurData = 0;
  logic intr, ackValid, eoiBcastValid, errIllegalVec;
  logic [7:0] ackVector, eoiBcastVector, procPriority, arbPriority;
  logic [9:0] spurReg;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ipc_top u0 (.*);

  // reference model state
  bit [255:0] mIrr, mIsr, mTmr;
  bit [7:0] mTpr, mAckVec, mEoiVec;
  bit [9:0] mSpur;
  bit mIntr, mEval, mAckV, mEoiV, mErr;

  function automatic int topOf(bit [255:0] v);
    int r = -1;
    for (int i = 0; i < 256; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic bit [7:0] pprOf(bit [255:0] isr, bit [7:0] tp);
    int s = topOf(isr);
    if (s < 0 || tp[7:4] >= s[7:4]) return tp;
    return {s[7:4], 4'h0};
  endfunction

  function automatic bit [7:0] aprOf(bit [255:0] irr, bit [255:0] isr, bit [7:0] tp);
    int s = topOf(isr);
    int q = topOf(irr);
    bit [3:0] tc = tp[7:4];
    bit [3:0] sc = (s < 0) ? 4'h0 : s[7:4];
    bit [3:0] qc = (q < 0) ? 4'h0 : q[7:4];
    if (tc >= qc && tc > sc) return tp;
    if ((tc & sc) > qc) return {tc & sc, 4'h0};
    return {qc, 4'h0};
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mIrr = '0; mIsr = '0; mTmr = '0; mTpr = 0; mSpur = 10'h0FF;
    mIntr = 0; mEval = 0; mAckV = 0; mAckVec = 0; mEoiV = 0; mEoiVec = 0; mErr = 0;
  endtask

  task automatic modelStep();
    int q = topOf(mIrr);
    int s = topOf(mIsr);
    bit [7:0] pp = pprOf(mIsr, mTpr);
    bit elig = (q >= 0) && (s < 0 || q > s) && (q[7:4] > mTpr[7:4]);
    bit serve = ackStrobe && (q >= 0) && ({q[7:4], 4'h0} > pp);
    bit eoiDo = eoiStrobe && (s >= 0) && (s[7:0] != mSpur[7:0]);
    bit legal = trigVector >= 8'd16;
    bit accept = trigValid && legal && (!mIrr[trigVector] || trigExtInt);
    bit lower = tprWrite && (tprData < mTpr);
    bit [255:0] nIrr = mIrr, nIsr = mIsr, nTmr = mTmr;
    mIntr = ackStrobe ? 1'b0 : (mIntr || (mEval && elig));
    mEval = accept || serve || eoiDo || lower;
    mAckV = ackStrobe;
    if (ackStrobe) mAckVec = serve ? q[7:0] : mSpur[7:0];
    mEoiV = eoiDo && mTmr[s[7:0]];
    if (eoiDo) begin mEoiVec = s[7:0]; nIsr[s[7:0]] = 0; nTmr[s[7:0]] = 0; end
    if (serve) begin nIrr[q[7:0]] = 0; nIsr[q[7:0]] = 1; end
    if (accept) begin nIrr[trigVector] = 1; nTmr[trigVector] = trigLevel; end
    mErr = mErr || (trigValid && !legal);
    if (tprWrite) mTpr = tprData;
    if (spurWrite) mSpur = {spurData[9:4], 4'hF};
    mIrr = nIrr; mIsr = nIsr; mTmr = nTmr;
  endtask

  task automatic compareAll();
    check("R5 intr", intr, mIntr);
    check("R7 ackValid", ackValid, mAckV);
    if (mAckV) check("R7 ackVector", ackVector, mAckVec);
    check("R8 eoiBcastValid", eoiBcastValid, mEoiV);
    if (mEoiV) check("R1 eoiBcastVector", eoiBcastVector, mEoiVec);
    check("R6 procPriority", procPriority, pprOf(mIsr, mTpr));
    check("R11 arbPriority", arbPriority, aprOf(mIrr, mIsr, mTpr));
    check("R2 errIllegalVec", errIllegalVec, mErr);
    check("R10 spurReg", spurReg, mSpur);
  endtask

  // one clock: inputs already driven; model follows the edge; compare at negedge
  task automatic cyc();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    trigValid = 0; trigExtInt = 0; trigLevel = 0; ackStrobe = 0; eoiStrobe = 0;
    tprWrite = 0; spurWrite = 0;
    compareAll();
  endtask

  task automatic trig(bit [7:0] v, bit lvl, bit ext);
    trigValid = 1; trigVector = v; trigLevel = lvl; trigExtInt = ext; cyc();
  endtask
  task automatic ack();  ackStrobe = 1; cyc(); endtask
  task automatic eoi();  eoiStrobe = 1; cyc(); endtask
  task automatic idle(); cyc(); endtask
  task automatic setTpr(bit [7:0] v); tprWrite = 1; tprData = v; cyc(); endtask
  task automatic setSpur(bit [9:0] v); spurWrite = 1; spurData = v; cyc(); endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R12 reset state
    check("R12 intr", intr, 0);
    check("R12 procPriority", procPriority, 0);
    check("R12 spurReg", spurReg, 10'h0FF);
    check("R12 errIllegalVec", errIllegalVec, 0);

    // R1 and R13: level vector, timing of intr, broadcast on retire
    trig(8'h45, 1, 0);
    check("R13 intr not yet", intr, 0);
    idle();
    check("R13 intr raised", intr, 1);
    ack();
    check("R1 ackVector", ackVector, 8'h45);
    check("R13 intr after ack", intr, 0);
    eoi();
    check("R1 broadcast", eoiBcastValid, 1);
    check("R1 broadcast vector", eoiBcastVector, 8'h45);

    // R3: duplicate trigger ignored, edge mode kept
    trig(8'h50, 0, 0);
    trig(8'h50, 1, 0);
    idle();
    ack();
    check("R3 ackVector", ackVector, 8'h50);
    eoi();
    check("R3 no broadcast", eoiBcastValid, 0);

    // R4: external delivery rewrites mode of a pending vector
    trig(8'h60, 0, 0);
    trig(8'h60, 1, 1);
    ack();
    check("R4 ackVector", ackVector, 8'h60);
    eoi();
    check("R4 broadcast", eoiBcastValid, 1);

    // R5: in-service gating
    trig(8'h80, 0, 0); idle(); ack();
    check("R6 ppr from isr", procPriority, 8'h80);
    trig(8'h70, 0, 0); idle(); idle();
    check("R5 below isr blocked", intr, 0);
    trig(8'h90, 0, 0); idle();
    check("R5 above isr raised", intr, 1);
    ack();
    check("R5 nested ack", ackVector, 8'h90);
    eoi(); idle();
    check("R8 ppr after eoi", procPriority, 8'h80);
    eoi(); idle();
    check("R5 lower vector now raised", intr, 1);
    ack(); eoi();

    // R9: lowering the task priority
    setTpr(8'h70);
    trig(8'h75, 0, 0); idle(); idle();
    check("R5 class gating", intr, 0);
    setTpr(8'h60); idle();
    check("R9 lowered tpr raises", intr, 1);
    ack();
    check("R6 ppr class", procPriority, 8'h70);
    eoi(); setTpr(8'h00);

    // R9: raising does not drop; stale ack returns spurious
    trig(8'h90, 0, 0); idle();
    setTpr(8'hA0);
    check("R9 raise keeps intr", intr, 1);
    ack();
    check("R7 stale ack spurious", ackVector, 8'hFF);
    setTpr(8'h00); idle();
    check("R9 re-raised", intr, 1);
    ack();
    check("R7 ack after lowering", ackVector, 8'h90);
    eoi();

    // R2: illegal vector
    trig(8'h05, 0, 0);
    check("R2 error set", errIllegalVec, 1);
    ack();
    check("R2 nothing pending", ackVector, 8'hFF);

    // R10 and R8: spurious register and retiring the spurious vector
    setSpur(10'h1A0);
    check("R10 low nibble forced", spurReg, 10'h1AF);
    setSpur(10'h33F);
    trig(8'h3F, 0, 0); idle(); ack();
    check("R7 ack 3F", ackVector, 8'h3F);
    eoi();
    check("R8 spurious not retired", procPriority, 8'h30);
    setSpur(10'h0FF);
    eoi();
    check("R8 retired", procPriority, 8'h00);

    // R11: arbitration priority
    setTpr(8'h20);
    trig(8'h45, 0, 0);
    check("R11 apr", arbPriority, 8'h40);
    idle(); ack(); eoi(); setTpr(8'h00);

    // random phase
    void'($urandom(32'd4711));
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 10;
      int p = $urandom % 8;
      bit [7:0] v;
      case (p)
        0: v = 8'h05; 1: v = 8'h10; 2: v = 8'h2A; 3: v = 8'h2F;
        4: v = 8'h3F; 5: v = 8'h81; 6: v = 8'hFF; default: v = 8'($urandom);
      endcase
      if (r < 3) trig(v, 1'($urandom), ($urandom % 8) == 0);
      else if (r == 3) ack();
      else if (r == 4) eoi();
      else if (r == 5) setTpr((p < 4) ? {p[1:0], 6'h0} : 8'($urandom));
      else if (r == 6 && p == 0) setSpur(10'($urandom));
      else idle();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule